// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address that one port of a synchronous RAM uses for its access. On every rising clock edge it decides, from three active-low strobes, whether to clear its address to zero, take an address from outside, step its own address up by one, or keep the address it already has. The address it settles on at that edge is driven on its output. The RAM uses that output as the access address for the same cycle.

The block sees no chip enable and no byte-lane enable. A step therefore happens even on a cycle in which the port is deselected. A load or a clear also happens whatever the enables are. The clear costs no extra cycle: the cycle that clears the address also accesses address zero. When neither the load strobe nor the step strobe is active, the output stays frozen. The external address bus is then ignored, so a read keeps returning the same word.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released with no strobe active, `acc_addr` is 0.
- R2: With `zero_n` high and `load_n` low at a rising edge, `acc_addr` equals the `ext_addr` sampled at that edge from that edge on.
- R3: With `zero_n` and `load_n` high and `step_n` low at a rising edge, `acc_addr` becomes its previous value plus one.
- R4: With `zero_n`, `load_n` and `step_n` all high at a rising edge, `acc_addr` keeps its value and any change on `ext_addr` has no effect.
- R5: With `zero_n` low at a rising edge, `acc_addr` becomes 0 at that edge, whatever `load_n`, `step_n` and `ext_addr` are.
- R6: When `load_n` and `step_n` are both low (and `zero_n` high), the load wins: `acc_addr` becomes `ext_addr`, not an incremented value.
- R7: A step from the all-ones address (8191 with the default 13-bit width) wraps `acc_addr` to 0.
- R8: The decision at each edge follows the fixed priority clear, then load, then step, then hold. The mode names used in the design are ZERO, LOAD, STEP and HOLD, and every mode can be entered from every other one on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the address |
| ext_addr | input | AW (13) | External address, taken when the load strobe is active |
| load_n | input | 1 | Active-low load strobe |
| step_n | input | 1 | Active-low count-enable strobe |
| zero_n | input | 1 | Active-low clear-to-zero strobe |
| acc_addr | output | AW (13) | Address used for the access in the current cycle |

## Verification
The hardest case to reach from the ports is the wrap from the all-ones address. Counting up to it would take thousands of steps, so the stimulus loads 8190 and then issues steps across the boundary. A long random phase drives all eight strobe combinations against an independent model. The external bus changes on every cycle of that phase, so holds and ignored buses are checked under a moving input rather than a quiet one. Directed sequences also put every mode right after every other one.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Action chosen at a clock edge, listed in decreasing priority
    typedef enum logic [1:0] {
        MODE_ZERO = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_STEP = 2'd2,
        MODE_HOLD = 2'd3
    } burst_mode_e;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import burst_pkg::*;
(
    input  logic        load_n,
    input  logic        step_n,
    input  logic        zero_n,
    output burst_mode_e mode
);

    // Fixed priority: clear, load, step, hold
    always_comb begin
        if (!zero_n)      mode = MODE_ZERO;
        else if (!load_n) mode = MODE_LOAD;
        else if (!step_n) mode = MODE_STEP;
        else              mode = MODE_HOLD;
    end

    always_comb begin
        AST_DECODE_PRIO: assert (zero_n || mode == MODE_ZERO); // R8
    end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  burst_mode_e   mode,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};

    logic [AW-1:0] addr_d;

    // Next-address selection by mode
    always_comb begin
        unique case (mode)
            MODE_ZERO: addr_d = '0;
            MODE_LOAD: addr_d = ext_addr;
            MODE_STEP: addr_d = addr_q + AW'(1);
            MODE_HOLD: addr_d = addr_q;
            default:   addr_d = addr_q;
        endcase
    end

    // Address state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_ZERO |=> addr_q == '0); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_LOAD |=> addr_q == $past(ext_addr)); // R2
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STEP && addr_q != ADDR_TOP) |=> addr_q == $past(addr_q) + AW'(1)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_HOLD |=> $stable(addr_q)); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STEP && addr_q == ADDR_TOP) |=> addr_q == '0); // R7

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          load_n,
    input  logic          step_n,
    input  logic          zero_n,
    output logic [AW-1:0] acc_addr
);

    burst_mode_e mode;

    burst_mode_decode u_decode (
        .load_n (load_n),
        .step_n (step_n),
        .zero_n (zero_n),
        .mode   (mode)
    );

    burst_addr_reg #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .ext_addr (ext_addr),
        .addr_q   (acc_addr)
    );

    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && !load_n && !step_n) |=> acc_addr == $past(ext_addr)); // R6

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

    localparam int AW = 13;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          load_n = 1'b1;
    logic          step_n = 1'b1;
    logic          zero_n = 1'b1;
    logic [AW-1:0] acc_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [AW-1:0] model = '0;
    exp_item_t sb[$];

    always #2 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .load_n(load_n), .step_n(step_n), .zero_n(zero_n),
        .acc_addr(acc_addr)
    );

    task automatic compare(input logic [AW-1:0] exp, input string tag);
        checks++;
        if (acc_addr !== exp) begin
            errors++;
            $display("FAIL %s: acc_addr=%0d expected=%0d", tag, acc_addr, exp);
        end
    endtask

    // Driver: apply strobes at falling edge, push expected result
    task automatic drive(input logic zn, input logic ln, input logic sn,
                         input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        zero_n = zn; load_n = ln; step_n = sn; ext_addr = a;
        if (!zn)      model = '0;
        else if (!ln) model = a;
        else if (!sn) model = model + AW'(1);
        sb.push_back('{model, tag});
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            compare(it.exp, it.tag);
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #7;
        compare('0, "R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        drive(1, 1, 1, 13'd77, "R1 after release");
        drive(1, 0, 1, 13'd100, "R2 load");
        drive(1, 1, 0, 13'd5, "R3 step");
        drive(1, 1, 0, 13'd6, "R3 step");
        drive(1, 1, 1, 13'd4000, "R4 hold ignores bus");
        drive(1, 1, 1, 13'd1234, "R4 hold ignores bus");
        drive(1, 0, 0, 13'd300, "R6 load beats step");
        drive(0, 0, 0, 13'd999, "R5 clear over load and step");
        drive(1, 1, 0, 13'd999, "R8 step after clear");
        drive(0, 1, 1, 13'd55, "R5 clear from hold strobes");
        drive(1, 0, 1, 13'd8190, "R2 load near top");
        drive(1, 1, 0, 13'd0, "R3 step to top");
        drive(1, 1, 0, 13'd0, "R7 wrap to zero");
        drive(1, 1, 0, 13'd0, "R7 step after wrap");
        // R8: every mode after every other mode
        for (int p = 0; p < 4; p++) begin
            for (int q = 0; q < 4; q++) begin
                drive(p != 0, p != 1, p != 2, AW'(p * 37 + 11), "R8 mode pair first");
                drive(q != 0, q != 1, q != 2, AW'(q * 53 + 9), "R8 mode pair second");
            end
        end
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            drive(r[0] | ($urandom_range(0, 3) != 0), r[1], r[2],
                  AW'($urandom), "R8 random strobes");
        end
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule